// File: doc/BRIEF.md
# Multi-Mode Serial Line Encoder

This block converts a serial NRZ data stream into a chosen line code: plain NRZ, NRZI, RZ or Manchester. It is clocked at twice the bit rate, so every bit period spans exactly two clock cycles, a first half and a second half. A free-running phase flag tracks which half is current. At each bit boundary the encoder samples the data bit and the mode select. It then drives the line level for both halves from registered state only.

The line output comes from a register. It can change only at a clock edge and never follows glitches on the data or mode inputs. Upstream logic presents one data bit per bit period. Any change on the data or mode inputs during the second cycle of a bit period is ignored until the next boundary. A synchronous reset restarts the bit framing and clears the NRZI reference level.

Top module: `lcode_serial_enc`

## Requirements
- R1: While `rst` is high at a rising edge, `line_out` is 0 after that edge. The next edge after reset is released begins a bit period. The NRZI reference level restarts at 0.
- R2: `data_in` and `mode_sel` are sampled only at the edge that begins a bit period. Values they hold at the mid-bit edge have no effect on the current bit.
- R3: With mode 2'b00 (NRZ), `line_out` equals the sampled data bit in both halves.
- R4: With mode 2'b01 (NRZI), a sampled 1 inverts the reference level and a 0 keeps it. `line_out` shows the updated reference in both halves. In any other mode the reference level is held unchanged.
- R5: With mode 2'b10 (RZ), a 0 gives low in both halves, and a 1 gives high in the first half and low in the second.
- R6: With mode 2'b11 (Manchester), a 0 gives low then high, and a 1 gives high then low.
- R7: `line_out` is registered. The first-half level appears after the edge that samples the bit, and the second-half level appears after the following edge. Bit periods alternate strictly with no gaps.
- R8: A new value on `mode_sel` is applied starting with the first bit period that begins after it is presented. The bit in progress keeps its mode in its second half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Line code: 00 NRZ, 01 NRZI, 10 RZ, 11 Manchester |
| data_in | input | 1 | NRZ data bit, sampled at the start of each bit period |
| line_out | output | 1 | Registered encoded line level |

## Verification
Assertions check the following on every cycle:
- The half-bit phase alternates.
- The captured bit and mode stay frozen through the second half.
- The RZ second half is always low.
- Manchester always flips level at mid-bit.
- NRZ and NRZI hold their level across mid-bit.

Some behaviours are shown only by the bench scenarios:
- The absolute levels for each data value.
- The NRZI reference running across many bits and across mode switches.
- The way reset restarts both the framing and the reference.
- The disregard of inputs that change at mid-bit.

The bench compares each half against a reference model that runs on random bits and modes.

// File: rtl/lcode_pkg.sv
package lcode_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    LM_NRZ   = 2'b00,
    LM_NRZI  = 2'b01,
    LM_RZ    = 2'b10,
    LM_MANCH = 2'b11
  } lmode_e;
endpackage

// File: rtl/lcode_phase.sv
module lcode_phase (
  input  logic clk,
  input  logic rst,
  output logic half_q,
  output logic bit_start
);
  always_ff @(posedge clk) begin
    if (rst) half_q <= 1'b0;
    else     half_q <= ~half_q;
  end

  assign bit_start = ~half_q;

  p_phase_rise_r7: assert property (@(posedge clk) disable iff (rst)
    !half_q |=> half_q);
  p_phase_fall_r7: assert property (@(posedge clk) disable iff (rst)
    half_q |=> !half_q);
endmodule

// File: rtl/lcode_capture.sv
module lcode_capture
  import lcode_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   bit_start,
  input  logic   data_in,
  input  lmode_e mode_in,
  output logic   bit_q,
  output lmode_e mode_q,
  output logic   ref_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q  <= 1'b0;
      mode_q <= LM_NRZ;
      ref_q  <= 1'b0;
    end else if (bit_start) begin
      bit_q  <= data_in;
      mode_q <= mode_in;
      if (mode_in == LM_NRZI) ref_q <= ref_q ^ data_in;
    end
  end

  // R2 / R8: captured bit and mode cannot move at mid-bit
  p_capture_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !bit_start |=> ($stable(bit_q) && $stable(mode_q) && $stable(ref_q)));
  // R4: reference never moves while a non-NRZI bit is captured
  p_ref_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_start && mode_in != LM_NRZI) |=> $stable(ref_q));
endmodule

// File: rtl/lcode_level.sv
module lcode_level
  import lcode_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   bit_start,
  input  logic   data_in,
  input  lmode_e mode_in,
  input  logic   ref_q,
  input  logic   bit_q,
  input  lmode_e mode_q,
  output logic   line_q
);
  logic first_lvl;
  logic second_lvl;

  always_comb begin
    unique case (mode_in)
      LM_NRZ:   first_lvl = data_in;
      LM_NRZI:  first_lvl = ref_q ^ data_in;
      LM_RZ:    first_lvl = data_in;
      LM_MANCH: first_lvl = data_in;
      default:  first_lvl = 1'b0;
    endcase
  end

  always_comb begin
    unique case (mode_q)
      LM_NRZ:   second_lvl = bit_q;
      LM_NRZI:  second_lvl = ref_q;
      LM_RZ:    second_lvl = 1'b0;
      LM_MANCH: second_lvl = ~bit_q;
      default:  second_lvl = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            line_q <= 1'b0;
    else if (bit_start) line_q <= first_lvl;
    else                line_q <= second_lvl;
  end

  p_rz_low_r5: assert property (@(posedge clk) disable iff (rst)
    (!bit_start && mode_q == LM_RZ) |=> !line_q);
  p_manch_flip_r6: assert property (@(posedge clk) disable iff (rst)
    (!bit_start && mode_q == LM_MANCH) |=> (line_q != $past(line_q)));
  p_level_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!bit_start && (mode_q == LM_NRZ || mode_q == LM_NRZI)) |=> $stable(line_q));
endmodule

// File: rtl/lcode_serial_enc.sv
module lcode_serial_enc
  import lcode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              data_in,
  output logic              line_out
);
  logic   half_q;
  logic   bit_start;
  logic   bit_q;
  logic   ref_q;
  lmode_e mode_q;
  lmode_e mode_in;

  assign mode_in = lmode_e'(mode_sel);

  lcode_phase u_phase (
    .clk       (clk),
    .rst       (rst),
    .half_q    (half_q),
    .bit_start (bit_start)
  );

  lcode_capture u_capture (
    .clk       (clk),
    .rst       (rst),
    .bit_start (bit_start),
    .data_in   (data_in),
    .mode_in   (mode_in),
    .bit_q     (bit_q),
    .mode_q    (mode_q),
    .ref_q     (ref_q)
  );

  lcode_level u_level (
    .clk       (clk),
    .rst       (rst),
    .bit_start (bit_start),
    .data_in   (data_in),
    .mode_in   (mode_in),
    .ref_q     (ref_q),
    .bit_q     (bit_q),
    .mode_q    (mode_q),
    .line_q    (line_out)
  );

  // R1: line is low right after a reset edge
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> !line_out);
endmodule

// File: tb/sim_lcode_serial_enc.sv
module sim_lcode_serial_enc;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic       data_in = 1'b0;
  logic       line_out;

  int checks = 0;
  int errors = 0;
  logic ref_m = 1'b0;

  lcode_serial_enc u0 (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .data_in  (data_in),
    .line_out (line_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_lvl(logic [1:0] m, logic d, logic r_after, logic second);
    case (m)
      2'b00:   return d;
      2'b01:   return r_after;
      2'b10:   return second ? 1'b0 : d;
      default: return second ? ~d : d;
    endcase
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'b00:   return "R3 NRZ";
      2'b01:   return "R4 NRZI";
      2'b10:   return "R5 RZ";
      default: return "R6 Manchester";
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: line_out actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // one bit period; inputs scrambled at mid-bit (R2, R8)
  task automatic send_bit(logic d, logic [1:0] m);
    logic r_after;
    mode_sel = m;
    data_in  = d;
    r_after  = (m == 2'b01) ? (ref_m ^ d) : ref_m;
    @(posedge clk); @(negedge clk);
    check({mode_tag(m), " first half R7"}, line_out, exp_lvl(m, d, r_after, 1'b0));
    data_in  = ~d;
    mode_sel = $urandom_range(0, 3);
    @(posedge clk); @(negedge clk);
    check({mode_tag(m), " second half R2 R8"}, line_out, exp_lvl(m, d, r_after, 1'b1));
    ref_m = r_after;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    data_in = 1'b1;
    mode_sel = 2'b11;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset level", line_out, 1'b0);
    rst = 1'b0;
    ref_m = 1'b0;

    // R1/R4: first NRZI bit after reset starts from reference 0
    send_bit(1'b1, 2'b01);
    send_bit(1'b1, 2'b01);
    send_bit(1'b0, 2'b01);
    send_bit(1'b1, 2'b01);
    // R4: reference held across other modes
    send_bit(1'b1, 2'b00);
    send_bit(1'b1, 2'b11);
    send_bit(1'b0, 2'b01);
    send_bit(1'b1, 2'b01);
    // each mode with both data values
    for (int m = 0; m < 4; m++) begin
      send_bit(1'b0, m[1:0]);
      send_bit(1'b1, m[1:0]);
    end

    // R1: reset mid-stream restarts framing and reference
    rst = 1'b1;
    data_in = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 mid-stream reset", line_out, 1'b0);
    rst = 1'b0;
    ref_m = 1'b0;
    send_bit(1'b0, 2'b01);
    send_bit(1'b1, 2'b01);

    // constrained random bits and modes
    for (int i = 0; i < 400; i++) begin
      send_bit(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule